// File: doc/BRIEF.md
# Timed Waveform Playback Sequencer

This block replays a stored waveform towards a digital-to-analog converter, one sample at a time. For every sample it first asks an external memory agent for the word at the current sample index. It then hands that word, with a register-select bit added on top, to an external serial-transmit agent. Both agents share one completion line and use a four-phase request/acknowledge protocol. A programmable pacing timer sets how often samples may start. A second bound limits how long the block waits for a serial transfer.

Software or a controller sets the waveform length, pacing and send bound, then raises `run`. In single-shot mode the block stops on the last sample and raises `finished`. In loop mode it wraps back to sample zero and keeps going. Loop mode can be switched on while a single-shot pass is already under way. Dropping `run` at any point ends playback cleanly once the open handshake has closed.

Top module: `wave_player`

## Requirements
- R1: Each word sent to the serial agent on `dac_word` is the fetched sample in the low SAMPLE_W bits, with bit SAMPLE_W set to 1 (the converter's data-register select). The word stays stable while the send request is raised.
- R2: `req` encodes the transaction: 2'b01 asks the memory agent to read the sample at address `sample_idx` into `mem_word`, and 2'b10 asks the serial agent to transmit `dac_word`. The value 2'b11 never appears.
- R3: Four-phase handshake. In the cycle after `ack` is seen high, `req` is 0. No new request is raised while `ack` is still high.
- R4: Samples are fetched and sent in index order 0, 1, ... wave_len-1. The index only steps by +1 or returns to 0, and a single-shot run delivers exactly wave_len words.
- R5: With `loop_en` high, the index wraps to 0 after sample wave_len-1 and playback repeats without end. `finished` stays low.
- R6: Raising `loop_en` during a single-shot run makes the block wrap at the end instead of finishing.
- R7: In single-shot mode, `finished` rises after the last word has been sent and stays high while `run` is high. Once `run` falls, `finished` clears and `ready` rises.
- R8: If `run` falls mid-waveform, any open handshake is completed and the block goes idle without advancing `sample_idx` further. `ready` rises once it is idle.
- R9: Successive fetch requests start at least `gap_cycles` clock cycles apart.
- R10: If the serial agent does not acknowledge within `send_limit` cycles, the send request is dropped after exactly that many cycles (for a bound of at least 1). The sample counts as sent, and playback continues with the next sample.
- R11: `wave_len`, `gap_cycles` and `send_limit` are captured when a run starts. Later changes have no effect on that run.
- R12: A new run starts at index 0 with `finished` low, whether the previous run completed or was interrupted.
- R13: After reset, `ready` is 1, `req` is 0, `finished` is 0 and `sample_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start and continue playback while high |
| loop_en | input | 1 | Wrap to sample 0 after the last sample |
| wave_len | input | ADDR_W | Number of samples, at least 1 |
| gap_cycles | input | TIMER_W | Minimum cycles between sample starts |
| send_limit | input | WAIT_W | Maximum cycles to wait for a serial acknowledge |
| ack | input | 1 | Shared completion from the memory and serial agents |
| mem_word | input | SAMPLE_W | Sample returned by the memory agent |
| req | output | 2 | Bit 0: memory read, bit 1: serial send |
| dac_word | output | SAMPLE_W+1 | Word for the serial agent, select bit on top |
| sample_idx | output | ADDR_W | Current sample index, also the memory read address |
| ready | output | 1 | High while idle |
| finished | output | 1 | Single-shot pass complete |

## Verification
The bench builds the block with ADDR_W=11, TIMER_W=6 and WAIT_W=4. A 1024-sample waveform therefore fills half the index range. A pacing value of 63 drives the pacing counter to its saturation point. A send bound of 5 makes a non-responding serial agent time out within a few cycles. Model agents with adjustable acknowledge delay run single-shot, looping, live loop switching, interruption, restart and configuration-change scenarios. Every received word and every fetch address is compared against a pattern computed in the bench.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FETCH_REL,
      ST_SEND,
      ST_SEND_REL,
      ST_GAP,
      ST_DONE
   } wp_state_e;

   localparam logic [1:0] REQ_NONE  = 2'b00;
   localparam logic [1:0] REQ_FETCH = 2'b01;
   localparam logic [1:0] REQ_SEND  = 2'b10;

endpackage

// File: rtl/wp_span_counter.sv
module wp_span_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         reached
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_next_ext;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clr)              cnt_q <= '0;
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else          cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   // count of cycles including the current one, compared to the bound
   assign cnt_next_ext = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
   assign reached      = cnt_next_ext >= {1'b0, limit};

endmodule

// File: rtl/wp_word_latch.sv
module wp_word_latch #(
   parameter int SAMPLE_W = 20,
   parameter bit SEL_BIT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [SAMPLE_W-1:0] mem_word,
   output logic [SAMPLE_W:0]   dac_word
);
   logic [SAMPLE_W-1:0] sample_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sample_q <= '0;
      else if (capture) sample_q <= mem_word;
   end

   assign dac_word = {SEL_BIT, sample_q};

endmodule

// File: rtl/wp_seq.sv
module wp_seq
   import wp_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int TIMER_W = 16,
   parameter int WAIT_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               loop_en,
   input  logic [ADDR_W-1:0]  wave_len,
   input  logic [TIMER_W-1:0] gap_cycles,
   input  logic [WAIT_W-1:0]  send_limit,
   input  logic               ack,
   input  logic               gap_reached,
   input  logic               wait_reached,
   output logic [1:0]         req,
   output logic [ADDR_W-1:0]  sample_idx,
   output logic               ready,
   output logic               finished,
   output logic               start_pulse,
   output logic               wait_clr,
   output logic               capture,
   output logic [TIMER_W-1:0] gap_q,
   output logic [WAIT_W-1:0]  lim_q
);
   wp_state_e         state_q, state_d;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] len_q;
   logic              fin_q;
   logic              last;
   logic              launch;
   logic              advance;

   assign last = (cnt_q == (len_q - 1'b1));

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:      if (run && !ack) state_d = ST_FETCH;
         ST_FETCH:     if (ack) state_d = ST_FETCH_REL;
         ST_FETCH_REL: if (!ack) state_d = run ? ST_SEND : ST_IDLE;
         ST_SEND:      if (ack || wait_reached) state_d = ST_SEND_REL;
         ST_SEND_REL: begin
            if (!ack) begin
               if (!run)                 state_d = ST_IDLE;
               else if (last && !loop_en) state_d = ST_DONE;
               else                      state_d = ST_GAP;
            end
         end
         ST_GAP: begin
            if (!run)             state_d = ST_IDLE;
            else if (gap_reached) state_d = ST_FETCH;
         end
         ST_DONE:      if (!run) state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   assign launch      = (state_q == ST_IDLE) && (state_d == ST_FETCH);
   assign advance     = (state_q == ST_SEND_REL) && (state_d == ST_GAP);
   assign start_pulse = (state_d == ST_FETCH) && (state_q != ST_FETCH);
   assign wait_clr    = (state_q != ST_SEND);
   assign capture     = (state_q == ST_FETCH) && ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         gap_q   <= '0;
         lim_q   <= '0;
         fin_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         fin_q   <= (state_d == ST_DONE);
         if (launch) begin
            cnt_q <= '0;
            len_q <= wave_len;
            gap_q <= gap_cycles;
            lim_q <= send_limit;
         end else if (advance) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      case (state_q)
         ST_FETCH: req = REQ_FETCH;
         ST_SEND:  req = REQ_SEND;
         default:  req = REQ_NONE;
      endcase
   end

   assign sample_idx = cnt_q;
   assign ready      = (state_q == ST_IDLE);
   assign finished   = fin_q;

   AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req != REQ_NONE && ack) |=> (req == REQ_NONE)); // R3
   AST_NO_REQ_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (req == REQ_NONE && ack) |=> (req == REQ_NONE)); // R3
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0))); // R4
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && len_q != '0) |-> (cnt_q < len_q)); // R4
   AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (finished && run) |=> finished); // R7
   AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP && !gap_reached) |=> (state_q != ST_FETCH)); // R9
   AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND && wait_reached && !ack) |=> (req == REQ_NONE)); // R10

endmodule

// File: rtl/wave_player.sv
module wave_player #(
   parameter int SAMPLE_W  = 20,
   parameter int ADDR_W    = 12,
   parameter int TIMER_W   = 16,
   parameter int WAIT_W    = 16,
   parameter bit SAT_TIMER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               loop_en,
   input  logic [ADDR_W-1:0]  wave_len,
   input  logic [TIMER_W-1:0] gap_cycles,
   input  logic [WAIT_W-1:0]  send_limit,
   input  logic               ack,
   input  logic [SAMPLE_W-1:0] mem_word,
   output logic [1:0]         req,
   output logic [SAMPLE_W:0]  dac_word,
   output logic [ADDR_W-1:0]  sample_idx,
   output logic               ready,
   output logic               finished
);
   localparam int DAC_W = SAMPLE_W + 1;

   generate
      if (SAMPLE_W < 1) begin : g_bad_sample
         $error("SAMPLE_W must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (TIMER_W < 1 || WAIT_W < 1) begin : g_bad_timer
         $error("TIMER_W and WAIT_W must be at least 1");
      end
   endgenerate

   logic               start_pulse;
   logic               wait_clr;
   logic               capture;
   logic               gap_reached;
   logic               wait_reached;
   logic [TIMER_W-1:0] gap_q;
   logic [WAIT_W-1:0]  lim_q;
   logic [DAC_W-1:0]   word_w;

   wp_seq #(
      .ADDR_W (ADDR_W),
      .TIMER_W(TIMER_W),
      .WAIT_W (WAIT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .loop_en     (loop_en),
      .wave_len    (wave_len),
      .gap_cycles  (gap_cycles),
      .send_limit  (send_limit),
      .ack         (ack),
      .gap_reached (gap_reached),
      .wait_reached(wait_reached),
      .req         (req),
      .sample_idx  (sample_idx),
      .ready       (ready),
      .finished    (finished),
      .start_pulse (start_pulse),
      .wait_clr    (wait_clr),
      .capture     (capture),
      .gap_q       (gap_q),
      .lim_q       (lim_q)
   );

   wp_span_counter #(
      .W       (TIMER_W),
      .SATURATE(SAT_TIMER)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_pulse),
      .limit  (gap_q),
      .reached(gap_reached)
   );

   wp_span_counter #(
      .W       (WAIT_W),
      .SATURATE(1'b1)
   ) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wait_clr),
      .limit  (lim_q),
      .reached(wait_reached)
   );

   wp_word_latch #(
      .SAMPLE_W(SAMPLE_W),
      .SEL_BIT (1'b1)
   ) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .mem_word(mem_word),
      .dac_word(word_w)
   );

   assign dac_word = word_w;

   AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      req[1] |-> $stable(dac_word)); // R1
   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req)); // R2

endmodule

// File: tb/test_wave_player.sv
module test_wave_player;
   localparam int AW = 11;
   localparam int SW = 20;
   localparam int TW = 6;
   localparam int WW = 4;
   localparam int LOGN = 4096;

   // columns: length, gap, send bound, seed, ack delay, expected words
   localparam int NVEC = 5;
   localparam int VEC [NVEC][6] = '{
      '{1,    0,  1,  3, 0, 1},
      '{7,    9,  4, 11, 2, 7},
      '{5,   63, 15,  2, 3, 5},
      '{64,  20, 14,  5, 1, 64},
      '{1024, 20, 14, 8, 0, 1024}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          loop_en = 1'b0;
   logic [AW-1:0] wave_len = '0;
   logic [TW-1:0] gap_cycles = '0;
   logic [WW-1:0] send_limit = '0;
   logic          ack = 1'b0;
   logic [SW-1:0] mem_word = '0;
   logic [1:0]    req;
   logic [SW:0]   dac_word;
   logic [AW-1:0] sample_idx;
   logic          ready;
   logic          finished;

   always #4 clk = ~clk;

   wave_player #(
      .SAMPLE_W(SW), .ADDR_W(AW), .TIMER_W(TW), .WAIT_W(WW)
   ) i_wave_player (
      .clk(clk), .rst_n(rst_n), .run(run), .loop_en(loop_en),
      .wave_len(wave_len), .gap_cycles(gap_cycles), .send_limit(send_limit),
      .ack(ack), .mem_word(mem_word), .req(req), .dac_word(dac_word),
      .sample_idx(sample_idx), .ready(ready), .finished(finished)
   );

   int tests = 0;
   int fails = 0;
   int seed = 0;
   int ack_delay = 0;
   bit spi_stall = 1'b0;
   logic [SW:0] recv [LOGN];
   int addr_log [LOGN];
   int nrecv, nfetch, cyc, last_fetch, min_space;
   int send_hi, max_send_hi, nsend_req, hs_viol, wcnt;
   bit prev0, fin_seen;

   function automatic logic [SW-1:0] pat(input int a, input int s);
      int v;
      v = (a * 40503) ^ (s * 2654435) ^ (a << 11);
      return v[SW-1:0];
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic clear_log();
      nrecv = 0; nfetch = 0; last_fetch = -1; min_space = 1000000;
      max_send_hi = 0; nsend_req = 0; hs_viol = 0; fin_seen = 1'b0;
   endtask

   // memory and serial agents
   initial begin
      cyc = 0; prev0 = 1'b0; send_hi = 0; wcnt = 0;
      clear_log();
      forever begin
         @(negedge clk);
         cyc++;
         if (finished) fin_seen = 1'b1;
         if (req == 2'b11) hs_viol++;
         if (ack && req != 2'b00) hs_viol++;
         if (req[0] && !prev0) begin
            if (nfetch < LOGN) addr_log[nfetch] = int'(sample_idx);
            nfetch++;
            if (last_fetch >= 0 && (cyc - last_fetch) < min_space) min_space = cyc - last_fetch;
            last_fetch = cyc;
         end
         prev0 = req[0];
         if (req[1]) begin
            send_hi++;
            if (send_hi == 1) nsend_req++;
            if (send_hi > max_send_hi) max_send_hi = send_hi;
         end else send_hi = 0;
         if (!ack) begin
            if (req != 2'b00) begin
               wcnt++;
               if (wcnt > ack_delay && !(req[1] && spi_stall)) begin
                  if (req[0]) mem_word = pat(int'(sample_idx), seed);
                  else begin
                     if (nrecv < LOGN) recv[nrecv] = dac_word;
                     nrecv++;
                  end
                  ack = 1'b1;
               end
            end else wcnt = 0;
         end else if (req == 2'b00) begin
            ack = 1'b0;
            wcnt = 0;
         end
      end
   end

   task automatic start(input int len, input int gap, input int lim, input bit lp);
      @(negedge clk);
      clear_log();
      wave_len = AW'(len); gap_cycles = TW'(gap); send_limit = WW'(lim);
      loop_en = lp; run = 1'b1;
   endtask

   task automatic wait_recv(input int n, input int maxc);
      for (int k = 0; k < maxc && nrecv < n; k++) @(negedge clk);
   endtask

   task automatic wait_fin(input int maxc);
      for (int k = 0; k < maxc && !finished; k++) @(negedge clk);
   endtask

   task automatic stop_run(input string rq);
      @(negedge clk); run = 1'b0;
      for (int k = 0; k < 200 && !ready; k++) @(negedge clk);
      chk(ready && req == 2'b00, rq, {ready, req}, 3'b100);
   endtask

   // compare received words and fetch addresses with the expected pattern
   task automatic check_words(input int len, input string rq);
      int bad_w, bad_a, bi;
      bad_w = 0; bad_a = 0; bi = -1;
      for (int i = 0; i < nrecv && i < LOGN; i++) begin
         if (recv[i] != {1'b1, pat(i % len, seed)}) begin
            bad_w++;
            if (bi < 0) bi = i;
         end
         if (addr_log[i] != i % len) bad_a++;
      end
      if (bi < 0) chk(1'b1, rq, 0, 0);
      else chk(1'b0, rq, int'(recv[bi]), int'({1'b1, pat(bi % len, seed)}));
      chk(bad_a == 0, "R4 address order", bad_a, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int idx_at, fetch_at, recv_at;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(ready && req == 2'b00 && !finished && sample_idx == '0, "R13 reset state",
          {ready, req, finished}, 4'b1000);

      // table-driven single-shot runs
      for (int v = 0; v < NVEC; v++) begin
         seed = VEC[v][3]; ack_delay = VEC[v][4];
         start(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);
         wait_fin(60000);
         chk(finished, "R7 finished raised", finished, 1);
         chk(nrecv == VEC[v][5], "R4 word count", nrecv, VEC[v][5]);
         check_words(VEC[v][0], "R1 word content");
         chk(min_space >= VEC[v][1], "R9 fetch spacing", min_space, VEC[v][1]);
         chk(hs_viol == 0, "R3 R2 handshake", hs_viol, 0);
         repeat (5) @(negedge clk);
         chk(finished && nrecv == VEC[v][5], "R7 finished holds", finished, 1);
         @(negedge clk); run = 1'b0;
         @(negedge clk);
         chk(ready && !finished, "R7 idle after run low", {ready, finished}, 2'b10);
      end

      // R5 loop playback
      seed = 21; ack_delay = 1;
      start(6, 0, 8, 1'b1);
      wait_recv(20, 2000);
      chk(nrecv >= 20 && !fin_seen, "R5 loop keeps playing", nrecv, 20);
      check_words(6, "R5 wrapped words");
      stop_run("R8 stop from loop");

      // R6 loop enabled during a single-shot run
      seed = 33; ack_delay = 0;
      start(40, 3, 8, 1'b0);
      wait_recv(10, 2000);
      loop_en = 1'b1;
      wait_recv(100, 5000);
      chk(nrecv >= 100 && !fin_seen, "R6 live switch to loop", nrecv, 100);
      check_words(40, "R6 words after wrap");
      stop_run("R8 stop after switch");
      loop_en = 1'b0;

      // R8 interrupt a long single-shot run
      seed = 44; ack_delay = 1;
      start(1024, 10, 8, 1'b0);
      wait_recv(30, 2000);
      @(negedge clk);
      run = 1'b0;
      idx_at = int'(sample_idx);
      for (int k = 0; k < 200 && !ready; k++) @(negedge clk);
      chk(ready && req == 2'b00, "R8 idle after interrupt", {ready, req}, 3'b100);
      chk(int'(sample_idx) == idx_at, "R8 index frozen", int'(sample_idx), idx_at);
      chk(nrecv <= idx_at + 1 && !fin_seen, "R8 no extra words", nrecv, idx_at + 1);
      fetch_at = nfetch; recv_at = nrecv;
      repeat (30) @(negedge clk);
      chk(nfetch == fetch_at && nrecv == recv_at, "R8 stays stopped", nfetch, fetch_at);

      // R12 restart after interrupt
      seed = 45; ack_delay = 0;
      start(5, 2, 8, 1'b0);
      @(negedge clk);
      chk(!finished && sample_idx == '0, "R12 fresh start", int'(sample_idx), 0);
      wait_fin(2000);
      chk(nrecv == 5, "R12 full run after restart", nrecv, 5);
      check_words(5, "R12 words after restart");
      @(negedge clk); run = 1'b0; @(negedge clk);

      // R10 serial agent never answers
      seed = 50; spi_stall = 1'b1;
      start(3, 0, 5, 1'b0);
      wait_fin(2000);
      chk(finished, "R10 run completes despite timeouts", finished, 1);
      chk(nsend_req == 3 && nfetch == 3 && nrecv == 0, "R10 each sample attempted once",
          nsend_req, 3);
      chk(max_send_hi == 5, "R10 request width equals bound", max_send_hi, 5);
      spi_stall = 1'b0;
      @(negedge clk); run = 1'b0; @(negedge clk);

      // R11 configuration changed mid-run is ignored
      seed = 60;
      start(4, 0, 8, 1'b0);
      for (int k = 0; k < 100 && nfetch < 1; k++) @(negedge clk);
      wave_len = AW'(9); gap_cycles = TW'(40);
      wait_fin(2000);
      chk(nrecv == 4, "R11 latched length", nrecv, 4);
      chk(min_space < 40, "R11 latched spacing", min_space, 0);
      @(negedge clk); run = 1'b0; @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule